// File: doc/BRIEF.md
# Decimal-to-DDS Tuning Word Converter

This block turns a frequency given as eight unpacked decimal digits, in hertz, into the 32-bit phase increment that a direct digital synthesizer needs. The result is the output frequency times 2^32 divided by the reference frequency, rounded to nearest. No general multiplier or divider is used. The block walks the digits from the most significant one downwards in Horner form. For each digit it looks up a stored product of a fixed scaling constant and that digit. It adds the product into a 64-bit fixed-point accumulator that holds 32 fraction bits. Between digits it multiplies the accumulator by ten with two shifts and one addition.

The reference frequency is a parameter. It fixes both the ten table entries and a final left shift. The table constant is pre-scaled by a power of two so that it keeps as many significant bits as 40 bits allow. The shift then restores that power of two before rounding. A caller puts the digits on `digits_i` and pulses `start_i`. A fixed number of cycles later `done_o` pulses and `word_o` holds the new word. If any digit is not a decimal digit, the block reports an error instead of computing a word.

The control is a single state machine with these states:
- `ST_IDLE`: waits for start.
- `ST_ADD`: adds the table entry for the current digit.
- `ST_MUL10`: multiplies the accumulator by ten.
- `ST_SCALE`: applies the range shift.
- `ST_ROUND`: rounds and publishes the word.
- `ST_FAULT`: reports bad digits.

Its transitions are:
- idle→add: start with valid digits.
- idle→fault: start with a bad digit.
- add→mul10: more digits remain.
- add→scale: the last digit has been added.
- mul10→add, scale→round, round→idle and fault→idle: unconditional.

Top module: `bcd_tuning_word`

## Requirements
- R1: After reset, `word_o` is 0 and `done_o` and `err_o` are low.
- R2: Digit i of the frequency is `digits_i[4i+3:4i]`, with digit 7 (bits 31:28) the most significant. The frequency is the sum over i of digit i times 10^i.
- R3: Table entry d (d = 0..9) is round(d·2^(64−N)/FREF), 40 bits wide. For FREF = 125 MHz the entry for digit 1 is 0x112E0BE827, so a frequency of 1 Hz gives the word 34.
- R4: Let S be the sum of entry(digit i)·10^i. Let A be the low 64 bits of S shifted left by N. The word is A[63:32] plus A[31], taken modulo 2^32.
- R5: N is chosen from FREF as follows:
  - N = 0 for FREF of at least 151 MHz.
  - N = 1 for FREF from 76 MHz up to but not including 151 MHz.
  - N = 2 for FREF from 38 MHz up to but not including 76 MHz.
  - N = 3 below 38 MHz.
  - The default of 125 MHz therefore uses N = 1.
- R6: With valid digits, `done_o` goes high exactly 2·8+1 = 17 clock edges after the edge that samples `start_i`. It stays high for one cycle.
- R7: `word_o` changes only in a cycle where `done_o` is high. It holds its value until the next result.
- R8: The digits are captured at the accepting edge. A start while a conversion is running has no effect, and later changes of `digits_i` do not alter the result.
- R9: If any digit is above 9, `done_o` and `err_o` pulse together one edge after the accepting edge, and `word_o` becomes 0.
- R10: `err_o` is never high without `done_o`, and it stays low for valid digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| digits_i | input | 32 | Eight unpacked decimal digits, 4 bits each |
| word_o | output | 32 | Rounded tuning word |
| done_o | output | 1 | One-cycle pulse when a result or error is ready |
| err_o | output | 1 | Pulses with done_o when a digit was above 9 |

## Verification
A valid conversion finishes 17 edges after the accepting edge. A bad-digit request finishes one edge after it. Nothing is accepted in the cycle that completes a conversion.

The bench keeps a behavioural model that counts these edges down from each accepted start. It compares `done_o`, `err_o` and `word_o` with the model at every falling edge, so a result that arrives one cycle early or late is caught at once. Fixed-value checks read the held word several cycles after the pulse, and the hold rule keeps that word stable until then.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int ACC_W  = 64;
    localparam int FRAC_W = 32;
    localparam int COEF_W = 40;
    localparam int DIG_W  = 4;
    localparam int WORD_W = ACC_W - FRAC_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADD,
        ST_MUL10,
        ST_SCALE,
        ST_ROUND,
        ST_FAULT
    } tw_state_e;

    // Pre-scale exponent chosen from the reference frequency range
    function automatic int unsigned range_shift(longint unsigned fref);
        if (fref >= 64'd151_000_000)
            return 0;
        else if (fref >= 64'd76_000_000)
            return 1;
        else if (fref >= 64'd38_000_000)
            return 2;
        else
            return 3;
    endfunction

    // round(d * 2^(64-sh) / fref) truncated to the coefficient width
    function automatic logic [COEF_W-1:0] coef_entry(int unsigned d, int unsigned sh,
                                                     longint unsigned fref);
        logic [127:0] num;
        logic [127:0] quo;
        num = 128'(d) << (ACC_W - sh);
        num = num + 128'(fref / 2);
        quo = num / 128'(fref);
        return quo[COEF_W-1:0];
    endfunction
endpackage

// File: rtl/tw_digit_check.sv
module tw_digit_check
    import tw_pkg::*;
#(
    parameter int NDIG = 8
) (
    input  logic [NDIG*DIG_W-1:0] digits_i,
    output logic                  all_ok_o
);
    logic [NDIG-1:0] ok_vec;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        assign ok_vec[g] = (digits_i[g*DIG_W +: DIG_W] <= 4'd9);
    end

    assign all_ok_o = &ok_vec;
endmodule

// File: rtl/tw_coef_rom.sv
module tw_coef_rom
    import tw_pkg::*;
#(
    parameter longint unsigned FREF_HZ = 125_000_000,
    parameter int unsigned     SHIFT   = 1
) (
    input  logic [DIG_W-1:0]  digit_i,
    output logic [COEF_W-1:0] coef_o
);
    localparam int NENT = 10;

    logic [COEF_W-1:0] tbl [NENT];

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        assign tbl[g] = coef_entry(g, SHIFT, FREF_HZ);
    end

    always_comb begin
        coef_o = '0;
        for (int i = 0; i < NENT; i++) begin
            if (digit_i == DIG_W'(i))
                coef_o = tbl[i];
        end
    end
endmodule

// File: rtl/tw_times10.sv
module tw_times10
    import tw_pkg::*;
(
    input  logic [ACC_W-1:0] acc_i,
    output logic [ACC_W-1:0] acc_o
);
    logic [ACC_W-1:0] by4;
    logic [ACC_W-1:0] by5;

    always_comb begin
        by4   = acc_i << 2;
        by5   = by4 + acc_i;
        acc_o = by5 << 1;
    end
endmodule

// File: rtl/bcd_tuning_word.sv
module bcd_tuning_word
    import tw_pkg::*;
#(
    parameter longint unsigned FREF_HZ = 125_000_000,
    parameter int              NDIG    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [NDIG*DIG_W-1:0] digits_i,
    output logic [WORD_W-1:0]     word_o,
    output logic                  done_o,
    output logic                  err_o
);
    localparam int unsigned SH    = range_shift(FREF_HZ);
    localparam int          IDX_W = (NDIG > 1) ? $clog2(NDIG) : 1;

    tw_state_e             state_q, state_d;
    logic [IDX_W-1:0]      idx_q;
    logic [NDIG*DIG_W-1:0] dig_q;
    logic [ACC_W-1:0]      acc_q;
    logic [ACC_W-1:0]      acc_x10;
    logic [WORD_W-1:0]     word_q;
    logic                  done_q;
    logic                  err_q;
    logic                  digits_ok;
    logic [DIG_W-1:0]      cur_digit;
    logic [COEF_W-1:0]     coef;

    assign cur_digit = dig_q[DIG_W*idx_q +: DIG_W];

    tw_digit_check #(.NDIG(NDIG)) u_check (
        .digits_i (digits_i),
        .all_ok_o (digits_ok)
    );

    tw_coef_rom #(.FREF_HZ(FREF_HZ), .SHIFT(SH)) u_rom (
        .digit_i (cur_digit),
        .coef_o  (coef)
    );

    tw_times10 u_x10 (
        .acc_i (acc_q),
        .acc_o (acc_x10)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = digits_ok ? ST_ADD : ST_FAULT;
            ST_ADD:   state_d = (idx_q == '0) ? ST_SCALE : ST_MUL10;
            ST_MUL10: state_d = ST_ADD;
            ST_SCALE: state_d = ST_ROUND;
            ST_ROUND: state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            dig_q  <= '0;
            acc_q  <= '0;
            word_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dig_q <= digits_i;
                        idx_q <= IDX_W'(NDIG - 1);
                        acc_q <= '0;
                    end
                end
                ST_ADD: begin
                    acc_q <= acc_q + ACC_W'(coef);
                    if (idx_q != '0)
                        idx_q <= idx_q - 1'b1;
                end
                ST_MUL10: acc_q <= acc_x10;
                ST_SCALE: acc_q <= acc_q << SH;
                ST_ROUND: begin
                    word_q <= acc_q[ACC_W-1:FRAC_W] + WORD_W'(acc_q[FRAC_W-1]);
                    done_q <= 1'b1;
                end
                ST_FAULT: begin
                    word_q <= '0;
                    done_q <= 1'b1;
                    err_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign word_o = word_q;
    assign done_o = done_q;
    assign err_o  = err_q;

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_err_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> done_q);

    assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(word_q));

    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(dig_q));

    assert_table_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADD) |-> (cur_digit <= 4'd9));

    assert_fault_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && !digits_ok) |=> ##1 (done_q && err_q && word_q == '0));
endmodule

// File: tb/sim_bcd_tuning_word.sv
module sim_bcd_tuning_word;
    localparam longint unsigned FREF = 125_000_000;
    localparam int              NSH  = 1;   // R5: 125 MHz falls in the N = 1 range
    localparam int              LAT  = 17;  // R6

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] digits_i = '0;
    logic [31:0] word_o;
    logic        done_o;
    logic        err_o;

    int n_chk = 0;
    int n_bad = 0;

    bcd_tuning_word u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .digits_i(digits_i),
        .word_o(word_o), .done_o(done_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    function automatic logic [127:0] ref_coef(int unsigned d);
        logic [127:0] v;
        v = ((128'(d) << (64 - NSH)) + 128'(FREF / 2)) / 128'(FREF);
        return {88'b0, v[39:0]};
    endfunction

    function automatic logic [31:0] ref_word(logic [31:0] dg);
        logic [127:0] s;
        logic [127:0] p;
        logic [63:0]  a;
        s = '0;
        p = 128'd1;
        for (int i = 0; i < 8; i++) begin
            s = s + ref_coef(int'(dg[4*i +: 4])) * p;
            p = p * 128'd10;
        end
        s = s << NSH;
        a = s[63:0];
        return a[63:32] + {31'b0, a[31]};
    endfunction

    function automatic bit bad_digits(logic [31:0] dg);
        for (int i = 0; i < 8; i++)
            if (dg[4*i +: 4] > 4'd9) return 1'b1;
        return 1'b0;
    endfunction

    // cycle model
    int          m_cnt = 0;
    logic [31:0] m_pend = '0;
    logic        m_perr = 1'b0;
    logic [31:0] m_word = '0;
    logic        m_done = 1'b0;
    logic        m_err = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_word = '0; m_done = 1'b0; m_err = 1'b0;
        end else begin
            m_done = 1'b0;
            m_err  = 1'b0;
            if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_done = 1'b1;
                    m_err  = m_perr;
                    m_word = m_pend;
                end
            end else if (start_i) begin
                m_perr = bad_digits(digits_i);
                m_pend = m_perr ? 32'd0 : ref_word(digits_i);
                m_cnt  = m_perr ? 1 : LAT;
            end
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(done_o == m_done, "R6", 32'(done_o), 32'(m_done));
            chk(err_o == m_err, "R9 R10", 32'(err_o), 32'(m_err));
            chk(word_o == m_word, "R4 R7", word_o, m_word);
        end
    end

    task automatic run(logic [31:0] dg, int wait_cyc);
        @(negedge clk);
        digits_i = dg;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        repeat (wait_cyc) @(negedge clk);
    endtask

    int wd = 0;
    bit fin = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !fin) begin
            fin = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(word_o == 0 && !done_o && !err_o, "R1", word_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word_o == 0 && !done_o && !err_o, "R1", word_o, 32'd0);

        run(32'h0000_0001, 20);
        chk(word_o == 32'd34, "R3 R5", word_o, 32'd34);
        run(32'h1000_0000, 20);
        chk(word_o == 32'd343597384, "R2", word_o, 32'd343597384);
        chk(err_o == 1'b0, "R10", 32'(err_o), 32'd0);
        run(32'h0000_0000, 20);
        chk(word_o == 32'd0, "R4", word_o, 32'd0);
        run(32'h9999_9999, 20);
        chk(word_o == ref_word(32'h9999_9999), "R4", word_o, ref_word(32'h9999_9999));
        run(32'h1234_5678, 20);
        run(32'h0707_0707, 20);
        run(32'h5000_0003, 20);

        // R7: inputs change with no start, word holds
        digits_i = 32'h8888_8888;
        repeat (5) @(negedge clk);
        chk(word_o == ref_word(32'h5000_0003), "R7", word_o, ref_word(32'h5000_0003));

        // R8: second start while busy and changed digits are ignored
        run(32'h0000_0001, 4);
        digits_i = 32'h4444_4444;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        digits_i = 32'h9000_0000;
        repeat (16) @(negedge clk);
        chk(word_o == 32'd34, "R8", word_o, 32'd34);

        // R9: bad digit
        run(32'h0000_A000, 1);
        chk(word_o == 32'd0, "R9", word_o, 32'd0);
        repeat (4) @(negedge clk);

        // back-to-back: start held high
        @(negedge clk);
        digits_i = 32'h0246_8135;
        start_i  = 1'b1;
        repeat (40) @(negedge clk);
        start_i  = 1'b0;
        repeat (20) @(negedge clk);
        chk(word_o == ref_word(32'h0246_8135), "R4 R6", word_o, ref_word(32'h0246_8135));

        run(32'hF999_9999, 3);
        run(32'h0010_0000, 20);

        fin = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule